// File: doc/BRIEF.md
# Video Controller Command Address Latch

This block is the command register behind the control port of a video display controller. Software writes a 16-bit access address and a 6-bit command code through one 16-bit port. Because both do not fit in one word, they arrive in two consecutive writes. An internal half-complete flag records that the first half has been taken and that the next control write carries the second half. A control write that arrives with no half pending and carries the pattern `10` in its top two bits is a register write instead. It produces a one-cycle register-write pulse with an index and a value, and it leaves the address latch alone.

When the second half lands, the block signals the read-prefetch logic to discard what it holds. It also decides whether the new command asks for a DMA transfer. A transfer whose source selector names a fill is held armed until the next accepted data-port write. Every other transfer kind starts at once. Any data-port access or status read abandons a half-written command. The block also decodes the low nibble of the command into a target memory and a read/write direction for the access path that follows it.

Top module: `vdc_cmd_latch`

## Requirements
- R1: After reset, `acc_addr`, `cmd_code`, `cmd_half`, `fill_armed`, `dma_go`, `reg_wr` and `pf_clr` are all 0.
- R2: A control write with `cmd_half`=0 and `ctl_wdata[15:14]`≠`10` loads `acc_addr[13:0]` from `ctl_wdata[13:0]` and `cmd_code[1:0]` from `ctl_wdata[15:14]`. It keeps `acc_addr[15:14]` and `cmd_code[5:2]` and sets `cmd_half`. All of this is visible on the cycle after the write.
- R3: A control write with `cmd_half`=1 loads `acc_addr[15:14]` from `ctl_wdata[1:0]` and `cmd_code[5:2]` from `ctl_wdata[7:4]`. It keeps the lower address and code bits, clears `cmd_half`, and pulses `pf_clr` for one cycle.
- R4: A control write with `cmd_half`=0 and `ctl_wdata[15:14]`=`10` pulses `reg_wr` for one cycle with `reg_idx`=`ctl_wdata[12:8]` and `reg_val`=`ctl_wdata[7:0]`. It leaves `acc_addr`, `cmd_code` and `cmd_half` unchanged.
- R5: An accepted data read, an accepted data write or a status read clears `cmd_half`. `pf_clr` pulses only when the access was a data-port access and `cmd_half` was 1 at that moment.
- R6: On a command-completing write with `ctl_wdata[7]`=1 and `dma_en`=1, a selector `dma_src_sel`≠`10` gives a one-cycle `dma_go` with `dma_mode`=selector. A selector of `10` (fill) sets `fill_armed` with no `dma_go`.
- R7: While `fill_armed`=1, the next accepted data write gives a one-cycle `dma_go` with `dma_mode`=`10` and clears `fill_armed`.
- R8: While `dma_busy`=1 and `dma_mode`≠`10`, a data write is rejected. `data_wr_ok` stays 0, and `cmd_half` and `fill_armed` keep their values.
- R9: `acc_tgt` decodes `cmd_code[3:0]` as follows. 0 and 1 give 1 (VRAM). 3 and 8 give 2 (colour RAM). 4 and 5 give 3 (scroll RAM). 0xC gives 4 (byte-wide VRAM). Every other value gives 0 (none). `acc_wr` equals `cmd_code[0]`.
- R10: A command-completing write with `dma_en`=0 or `ctl_wdata[7]`=0 neither pulses `dma_go` nor leaves `fill_armed` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 16 | Control-port write data |
| data_rd | input | 1 | Data-port read strobe |
| data_wr | input | 1 | Data-port write strobe |
| stat_rd | input | 1 | Status read strobe |
| dma_en | input | 1 | DMA enable bit from the mode register |
| dma_src_sel | input | 2 | Transfer-kind selector (top bits of DMA source high) |
| dma_busy | input | 1 | A transfer engine is running |
| data_wr_ok | output | 1 | Data write accepted (combinational) |
| acc_addr | output | 16 | Access address |
| cmd_code | output | 6 | Command code |
| cmd_half | output | 1 | First half taken, second awaited |
| acc_tgt | output | 3 | Decoded target memory |
| acc_wr | output | 1 | Decoded write direction |
| pf_clr | output | 1 | One-cycle prefetch-discard pulse |
| reg_wr | output | 1 | One-cycle register-write pulse |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |
| dma_go | output | 1 | One-cycle transfer start |
| dma_mode | output | 2 | Kind of the latest requested transfer |
| fill_armed | output | 1 | Fill waiting for a data write |

## Verification
The assertions take it for granted that at most one of the four port strobes is high in any cycle. The block gives no priority between simultaneous control and data accesses, and one assertion flags a violation. The bench drives each strobe alone for exactly one cycle on a falling edge. It changes `dma_en`, `dma_src_sel` and `dma_busy` only while no strobe is high, so every transfer decision is made with stable inputs.

// File: rtl/vdc_cmd_pkg.sv
package vdc_cmd_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 16;
  localparam int CODE_W  = 6;
  localparam int LO_W    = 14;
  localparam int HI_W    = ADDR_W - LO_W;
  localparam int CLO_W   = 2;
  localparam int CHI_W   = CODE_W - CLO_W;
  localparam int RIDX_W  = 5;
  localparam int RVAL_W  = 8;
  localparam int SEL_W   = 2;
  localparam int TGT_W   = 3;
  localparam int DMA_BIT = 7;

  localparam logic [SEL_W-1:0] SEL_FILL = 2'b10;
  localparam logic [1:0]       TAG_REGW = 2'b10;

  typedef enum logic [TGT_W-1:0] {
    TGT_NONE  = 3'd0,
    TGT_VRAM  = 3'd1,
    TGT_CRAM  = 3'd2,
    TGT_VSRAM = 3'd3,
    TGT_VRAM8 = 3'd4
  } tgt_e;

  function automatic tgt_e decode_tgt(input logic [3:0] c);
    case (c)
      4'h0, 4'h1: decode_tgt = TGT_VRAM;
      4'h3, 4'h8: decode_tgt = TGT_CRAM;
      4'h4, 4'h5: decode_tgt = TGT_VSRAM;
      4'hC:       decode_tgt = TGT_VRAM8;
      default:    decode_tgt = TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vdc_cmd_seq.sv
module vdc_cmd_seq
  import vdc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              data_acc,
  input  logic              stat_rd,
  output logic              done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CODE_W-1:0] code_q,
  output logic              half_q,
  output logic              pfclr_q,
  output logic              regw_q,
  output logic [RIDX_W-1:0] ridx_q,
  output logic [RVAL_W-1:0] rval_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [CODE_W-1:0] code_d;
  logic              half_d, pfclr_d, regw_d, is_regw;

  assign is_regw = ctl_wr && !half_q && (ctl_wdata[DATA_W-1 -: 2] == TAG_REGW);
  assign done    = ctl_wr && half_q;

  always_comb begin
    addr_d  = addr_q;
    code_d  = code_q;
    half_d  = half_q;
    pfclr_d = 1'b0;
    regw_d  = 1'b0;
    if (ctl_wr) begin
      if (!half_q) begin
        if (is_regw) begin
          regw_d = 1'b1;
        end else begin
          addr_d[LO_W-1:0]  = ctl_wdata[LO_W-1:0];
          code_d[CLO_W-1:0] = ctl_wdata[DATA_W-1 -: CLO_W];
          half_d            = 1'b1;
        end
      end else begin
        addr_d[ADDR_W-1 -: HI_W]  = ctl_wdata[HI_W-1:0];
        code_d[CODE_W-1 -: CHI_W] = ctl_wdata[4 +: CHI_W];
        half_d                    = 1'b0;
        pfclr_d                   = 1'b1;
      end
    end else if (data_acc || stat_rd) begin
      half_d  = 1'b0;
      pfclr_d = half_q && data_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      code_q  <= '0;
      half_q  <= 1'b0;
      pfclr_q <= 1'b0;
      regw_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      code_q  <= code_d;
      half_q  <= half_d;
      pfclr_q <= pfclr_d;
      regw_q  <= regw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q <= '0;
      rval_q <= '0;
    end else if (is_regw) begin
      ridx_q <= ctl_wdata[8 +: RIDX_W];
      rval_q <= ctl_wdata[RVAL_W-1:0];
    end
  end

  // R2
  a_r2_first_half: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !half_q && !is_regw |=> half_q && addr_q[LO_W-1:0] == $past(ctl_wdata[LO_W-1:0])
      && $stable(addr_q[ADDR_W-1 -: HI_W]));
  // R3
  a_r3_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !half_q && pfclr_q && $stable(addr_q[LO_W-1:0]) && $stable(code_q[CLO_W-1:0]));
  // R4
  a_r4_regw_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    is_regw |=> regw_q && !half_q && $stable(addr_q) && $stable(code_q));
  // R5
  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && (data_acc || stat_rd) |=> !half_q);
  a_r5_no_stray_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !half_q && !ctl_wr |=> !pfclr_q);
endmodule

// File: rtl/vdc_cmd_dma.sv
module vdc_cmd_dma
  import vdc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             req_bit,
  input  logic             dma_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             data_wr,
  input  logic             dma_busy,
  output logic             wr_ok,
  output logic             go_q,
  output logic [SEL_W-1:0] mode_q,
  output logic             fill_q
);
  logic             go_d, fill_d, reject;
  logic [SEL_W-1:0] mode_d;

  assign reject = dma_busy && (mode_q != SEL_FILL);
  assign wr_ok  = data_wr && !reject;

  always_comb begin
    go_d   = 1'b0;
    fill_d = fill_q;
    mode_d = mode_q;
    if (done) begin
      fill_d = 1'b0;
      if (req_bit && dma_en) begin
        mode_d = sel;
        if (sel == SEL_FILL) fill_d = 1'b1;
        else                 go_d   = 1'b1;
      end
    end else if (wr_ok && fill_q) begin
      go_d   = 1'b1;
      fill_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      fill_q <= 1'b0;
      mode_q <= '0;
    end else begin
      go_q   <= go_d;
      fill_q <= fill_d;
      mode_q <= mode_d;
    end
  end

  // R6
  a_r6_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    done && req_bit && dma_en && sel != SEL_FILL |=> go_q && !fill_q);
  a_r6_fill_arm: assert property (@(posedge clk) disable iff (!rst_n)
    done && req_bit && dma_en && sel == SEL_FILL |=> fill_q && !go_q);
  // R7
  a_r7_fill_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !done && wr_ok && fill_q |=> go_q && !fill_q && mode_q == SEL_FILL);
  // R8
  a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy && mode_q != SEL_FILL |-> !wr_ok);
  // R10
  a_r10_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(req_bit && dma_en) |=> !go_q && !fill_q);
endmodule

// File: rtl/vdc_cmd_decode.sv
module vdc_cmd_decode
  import vdc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output tgt_e              tgt,
  output logic              is_wr
);
  assign tgt   = decode_tgt(code[3:0]);
  assign is_wr = code[0];

  // R9
  a_r9_cram_codes: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == TGT_CRAM |-> (code[3:0] == 4'h3 || code[3:0] == 4'h8));
  a_r9_vram8_read: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == TGT_VRAM8 |-> !is_wr);
endmodule

// File: rtl/vdc_cmd_latch.sv
module vdc_cmd_latch
  import vdc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              stat_rd,
  input  logic              dma_en,
  input  logic [SEL_W-1:0]  dma_src_sel,
  input  logic              dma_busy,
  output logic              data_wr_ok,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [CODE_W-1:0] cmd_code,
  output logic              cmd_half,
  output logic [TGT_W-1:0]  acc_tgt,
  output logic              acc_wr,
  output logic              pf_clr,
  output logic              reg_wr,
  output logic [RIDX_W-1:0] reg_idx,
  output logic [RVAL_W-1:0] reg_val,
  output logic              dma_go,
  output logic [SEL_W-1:0]  dma_mode,
  output logic              fill_armed
);
  logic done, data_acc;
  tgt_e tgt;

  assign data_acc = data_rd || data_wr_ok;
  assign acc_tgt  = tgt;

  vdc_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .data_acc(data_acc), .stat_rd(stat_rd), .done(done),
    .addr_q(acc_addr), .code_q(cmd_code), .half_q(cmd_half),
    .pfclr_q(pf_clr), .regw_q(reg_wr), .ridx_q(reg_idx), .rval_q(reg_val)
  );

  vdc_cmd_dma u_dma (
    .clk(clk), .rst_n(rst_n), .done(done), .req_bit(ctl_wdata[DMA_BIT]),
    .dma_en(dma_en), .sel(dma_src_sel), .data_wr(data_wr), .dma_busy(dma_busy),
    .wr_ok(data_wr_ok), .go_q(dma_go), .mode_q(dma_mode), .fill_q(fill_armed)
  );

  vdc_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .code(cmd_code), .tgt(tgt), .is_wr(acc_wr)
  );

  // input contract: one port strobe per cycle
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_wr, data_rd, data_wr, stat_rd}));
  // R8
  a_r8_keep_half: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !data_wr_ok && !ctl_wr && !data_rd && !stat_rd |=> $stable(cmd_half));
endmodule

// File: tb/sim_vdc_cmd_latch.sv
`timescale 1ns/1ps
module sim_vdc_cmd_latch;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_wr = 0, data_rd = 0, data_wr = 0, stat_rd = 0;
  logic [15:0] ctl_wdata = '0;
  logic        dma_en = 0, dma_busy = 0;
  logic [1:0]  dma_src_sel = 2'b00;
  logic        data_wr_ok, cmd_half, acc_wr, pf_clr, reg_wr, dma_go, fill_armed;
  logic [15:0] acc_addr;
  logic [5:0]  cmd_code;
  logic [2:0]  acc_tgt;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val;
  logic [1:0]  dma_mode;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vdc_cmd_latch u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [15:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic strobe_rd(); @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0; endtask
  task automatic strobe_st(); @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0; endtask
  task automatic strobe_wr(input logic exp_ok, input string tag);
    @(negedge clk); data_wr = 1; #1 chk(tag, data_wr_ok, exp_ok);
    @(negedge clk); data_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 addr", acc_addr, 0); chk("R1 code", cmd_code, 0);
    chk("R1 half", cmd_half, 0); chk("R1 fill", fill_armed, 0);
    chk("R1 go", dma_go, 0); chk("R1 regwr", reg_wr, 0); chk("R1 pfclr", pf_clr, 0);
  endtask

  task automatic t_two_write();
    ctl(16'h4123);
    chk("R2 addr", acc_addr, 16'h0123); chk("R2 code", cmd_code, 6'h01); chk("R2 half", cmd_half, 1);
    ctl(16'h00A2);
    chk("R3 addr", acc_addr, 16'h8123); chk("R3 code", cmd_code, 6'h29);
    chk("R3 half", cmd_half, 0); chk("R3 pfclr", pf_clr, 1);
    chk("R10 go", dma_go, 0); chk("R10 fill", fill_armed, 0);
    ctl(16'hC005);
    chk("R2 keep hi addr", acc_addr, 16'h8005); chk("R2 keep hi code", cmd_code, 6'h2B);
    chk("R2 no pfclr", pf_clr, 0);
    ctl(16'h0000);
    chk("R3 keep lo", acc_addr, 16'h0005); chk("R3 code lo kept", cmd_code, 6'h03);
  endtask

  task automatic t_regw();
    ctl(16'h8F02);
    chk("R4 pulse", reg_wr, 1); chk("R4 idx", reg_idx, 5'h0F); chk("R4 val", reg_val, 8'h02);
    chk("R4 addr kept", acc_addr, 16'h0005); chk("R4 code kept", cmd_code, 6'h03);
    chk("R4 half", cmd_half, 0);
    @(negedge clk); chk("R4 one cycle", reg_wr, 0);
  endtask

  task automatic t_decode(input logic [3:0] c, input logic [2:0] tgt);
    ctl({c[1:0], 14'h0000});
    ctl({8'h00, 2'b00, c[3:2], 4'h0});
    chk("R9 tgt", acc_tgt, tgt); chk("R9 dir", acc_wr, c[0]);
  endtask

  task automatic t_cancel();
    ctl(16'h0001); strobe_rd();
    chk("R5 rd half", cmd_half, 0); chk("R5 rd pfclr", pf_clr, 1);
    ctl(16'h0001); strobe_st();
    chk("R5 st half", cmd_half, 0); chk("R5 st no pfclr", pf_clr, 0);
    strobe_rd(); chk("R5 idle rd no pfclr", pf_clr, 0);
    ctl(16'h0001); strobe_wr(1'b1, "R5 wr ok");
    chk("R5 wr half", cmd_half, 0); chk("R5 wr pfclr", pf_clr, 1);
  endtask

  task automatic t_dma();
    dma_en = 1; dma_src_sel = 2'b11;
    ctl(16'h0000); ctl(16'h0080);
    chk("R6 go", dma_go, 1); chk("R6 mode", dma_mode, 2'b11); chk("R6 no fill", fill_armed, 0);
    @(negedge clk); chk("R6 one cycle", dma_go, 0);
    dma_src_sel = 2'b10;
    ctl(16'h0000); ctl(16'h0080);
    chk("R6 fill armed", fill_armed, 1); chk("R6 fill no go", dma_go, 0);
    strobe_rd(); chk("R7 read keeps arm", fill_armed, 1); chk("R7 read no go", dma_go, 0);
    strobe_wr(1'b1, "R7 wr ok");
    chk("R7 go", dma_go, 1); chk("R7 mode", dma_mode, 2'b10); chk("R7 disarm", fill_armed, 0);
    dma_src_sel = 2'b01;
    ctl(16'h0000); ctl(16'h0080);
    chk("R6 mode 01", dma_mode, 2'b01); chk("R6 go 01", dma_go, 1);
    dma_busy = 1;
    ctl(16'h0003); strobe_wr(1'b0, "R8 rejected");
    chk("R8 half kept", cmd_half, 1); chk("R8 no pfclr", pf_clr, 0);
    dma_busy = 0;
    strobe_wr(1'b1, "R8 accepted after busy");
    chk("R8 half cleared", cmd_half, 0);
    dma_en = 0; dma_src_sel = 2'b10;
    ctl(16'h0000); ctl(16'h0080);
    chk("R10 disabled go", dma_go, 0); chk("R10 disabled fill", fill_armed, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_two_write();
    t_regw();
    t_decode(4'h0, 3'd1); t_decode(4'h1, 3'd1); t_decode(4'h3, 3'd2);
    t_decode(4'h4, 3'd3); t_decode(4'h5, 3'd3); t_decode(4'h8, 3'd2);
    t_decode(4'hC, 3'd4); t_decode(4'h7, 3'd0); t_decode(4'hD, 3'd0);
    t_cancel();
    t_dma();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule